// File: doc/BRIEF.md
# Serial Wiper-Code Loader and Tap Decoder

This block receives an 8-bit wiper code for a 256-position digitally controlled resistor over a three-wire, receive-only serial link. The link has a serial clock, a serial data line and a select line that is active high. While select is high, each rising edge of the serial clock shifts one data bit into a shift register. The most significant bit arrives first. When select goes low, the current shift register contents are copied into the wiper register.

The three serial inputs are not related to the system clock. Each passes through a two-flop synchronizer, and both edge detections run in the system clock domain. The system clock must therefore run at least four times faster than the serial clock. The wiper register value is decoded into a one-hot bus that selects one of 256 ladder taps. A separate flag marks the zero-scale tap, which is the tap tied to the B end of the ladder. A one-cycle load strobe marks every update of the wiper register.

Top module: `serial_wiper_loader`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the wiper code is 0x80 (midscale), only tap_sel bit 128 is set, zero_tap is low and load_pulse is low.
- R2: Only rising edges of sclk seen while sel is high shift a bit in. Bits enter most significant first. An 8-bit window commits exactly the byte sent.
- R3: sclk edges while sel is low leave both the wiper register and the shift register unchanged, and no load_pulse is produced.
- R4: If more than eight bits arrive in one select window, only the last eight are committed.
- R5: If a select window carries fewer than eight bits, the commit still happens. The new bits fill the low end, and the upper bits are the earlier shift-register bits moved up by the number of new bits.
- R6: Reset clears the shift register to zero, so a short window right after reset commits the new bits with zeros above them.
- R7: load_pulse is high for exactly one system clock cycle, on the third rising clk edge after sel is seen low. The wiper code and tap_sel take their new values in that same cycle.
- R8: tap_sel is always one-hot, and bit N is set when the wiper code equals N (code 0x00 sets bit 0 and code 0xFF sets bit 255).
- R9: zero_tap is high exactly when the wiper code is 0x00.
- R10: A select window with no sclk rising edges still produces a load_pulse and commits the unchanged shift register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| sdata | input | 1 | Serial data, sampled on sclk rising edge |
| sel | input | 1 | Select, active high; its falling edge commits the word |
| wiper_code | output | 8 | Current wiper register value |
| tap_sel | output | 256 | One-hot tap select decoded from wiper_code |
| zero_tap | output | 1 | High when the zero-scale tap is selected |
| load_pulse | output | 1 | One-cycle strobe on every wiper register update |

## Verification
A commit is due on the third rising clk edge after sel is driven low. Two edges go to the synchronizer, and the third registers the wiper and load_pulse. tap_sel and zero_tap are combinational from the wiper, so they are due in that same cycle. The bench drives every input on the falling clk edge and counts falling edges after lowering sel. It checks that load_pulse is still low after the second rising edge, high with the expected code after the third, and low again after the fourth. Each serial clock phase is held for four system clock cycles, so every sclk edge clears the synchronizer well before the next edge arrives.

// File: rtl/wiper_pkg.sv
package wiper_pkg;

   // Default code width of the wiper register
   localparam int unsigned DEF_CODE_W = 8;

   // Decoder implementation variants
   typedef enum logic {
      DEC_COMPARE = 1'b0,  // one equality comparator per tap
      DEC_SHIFT   = 1'b1   // single barrel shift of a one
   } dec_style_e;

endpackage

// File: rtl/wl_sync.sv
module wl_sync #(
   parameter int unsigned WIDTH   = 3,
   parameter int unsigned STAGES  = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [WIDTH-1:0] chain [STAGES];

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("wl_sync: STAGES must be at least 2");
      end
      if (WIDTH < 1) begin : g_bad_width
         $error("wl_sync: WIDTH must be at least 1");
      end

      for (genvar g = 0; g < int'(STAGES); g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
               if (rst) chain[0] <= RST_VAL;
               else     chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk) begin
               if (rst) chain[g] <= RST_VAL;
               else     chain[g] <= chain[g-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/wl_shift_capture.sv
module wl_shift_capture #(
   parameter int unsigned CODE_W = wiper_pkg::DEF_CODE_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              sclk_s,
   input  logic              sdat_s,
   input  logic              sel_s,
   output logic [CODE_W-1:0] shift_q,
   output logic              commit
);

   logic sclk_d;
   logic sel_d;
   logic sclk_rise;
   logic sel_fall;

   generate
      if (CODE_W < 2) begin : g_bad_width
         $error("wl_shift_capture: CODE_W must be at least 2");
      end
   endgenerate

   // Delayed copies for edge detection in the system domain
   always_ff @(posedge clk) begin
      if (rst) begin
         sclk_d <= 1'b0;
         sel_d  <= 1'b0;
      end else begin
         sclk_d <= sclk_s;
         sel_d  <= sel_s;
      end
   end

   assign sclk_rise = sclk_s & ~sclk_d;
   assign sel_fall  = sel_d & ~sel_s;

   // Shift in MSB first; older bits fall off the top on overflow
   always_ff @(posedge clk) begin
      if (rst) begin
         shift_q <= '0;
      end else if (sclk_rise && sel_s) begin
         shift_q <= {shift_q[CODE_W-2:0], sdat_s};
      end
   end

   assign commit = sel_fall;

endmodule

// File: rtl/wl_tap_decode.sv
module wl_tap_decode #(
   parameter int unsigned CODE_W = wiper_pkg::DEF_CODE_W,
   parameter wiper_pkg::dec_style_e DEC_STYLE = wiper_pkg::DEC_COMPARE
) (
   input  logic [CODE_W-1:0]       code,
   output logic [(1<<CODE_W)-1:0]  tap_sel,
   output logic                    zero_tap
);

   localparam int unsigned TAPS = 1 << CODE_W;

   generate
      if (CODE_W > 12) begin : g_too_wide
         $error("wl_tap_decode: CODE_W too large for a one-hot decode");
      end

      if (DEC_STYLE == wiper_pkg::DEC_COMPARE) begin : g_cmp
         for (genvar t = 0; t < int'(TAPS); t++) begin : g_tap
            assign tap_sel[t] = (code == CODE_W'(t));
         end
      end else begin : g_shf
         assign tap_sel = {{(TAPS-1){1'b0}}, 1'b1} << code;
      end
   endgenerate

   // Zero-scale flag from the code itself, not from the decoded bus
   assign zero_tap = ~|code;

endmodule

// File: rtl/serial_wiper_loader.sv
module serial_wiper_loader #(
   parameter int unsigned CODE_W      = wiper_pkg::DEF_CODE_W,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned RESET_CODE  = 2 ** (CODE_W - 1),
   parameter wiper_pkg::dec_style_e DEC_STYLE = wiper_pkg::DEC_COMPARE
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    sclk,
   input  logic                    sdata,
   input  logic                    sel,
   output logic [CODE_W-1:0]       wiper_code,
   output logic [(1<<CODE_W)-1:0]  tap_sel,
   output logic                    zero_tap,
   output logic                    load_pulse
);

   localparam int unsigned TAPS = 1 << CODE_W;
   localparam logic [CODE_W-1:0] RST_WIPER = CODE_W'(RESET_CODE);

   generate
      if (RESET_CODE >= TAPS) begin : g_bad_reset
         $error("serial_wiper_loader: RESET_CODE exceeds code range");
      end
   endgenerate

   logic [2:0]        raw_in;
   logic [2:0]        sync_out;
   logic [CODE_W-1:0] shift_q;
   logic              commit;

   assign raw_in = {sel, sclk, sdata};

   wl_sync #(
      .WIDTH   (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b000)
   ) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (raw_in),
      .q   (sync_out)
   );

   wl_shift_capture #(
      .CODE_W (CODE_W)
   ) u_cap (
      .clk     (clk),
      .rst     (rst),
      .sclk_s  (sync_out[1]),
      .sdat_s  (sync_out[0]),
      .sel_s   (sync_out[2]),
      .shift_q (shift_q),
      .commit  (commit)
   );

   // Wiper register and update strobe
   always_ff @(posedge clk) begin
      if (rst) begin
         wiper_code <= RST_WIPER;
         load_pulse <= 1'b0;
      end else begin
         load_pulse <= commit;
         if (commit) wiper_code <= shift_q;
      end
   end

   wl_tap_decode #(
      .CODE_W    (CODE_W),
      .DEC_STYLE (DEC_STYLE)
   ) u_dec (
      .code     (wiper_code),
      .tap_sel  (tap_sel),
      .zero_tap (zero_tap)
   );

endmodule

// File: rtl/wiper_loader_chk.sv
module wiper_loader_chk #(
   parameter int unsigned CODE_W = wiper_pkg::DEF_CODE_W
) (
   input logic                   clk,
   input logic                   rst,
   input logic [CODE_W-1:0]      wiper_code,
   input logic [(1<<CODE_W)-1:0] tap_sel,
   input logic                   zero_tap,
   input logic                   load_pulse
);

   AST_TAP_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $countones(tap_sel) == 1); // R8

   AST_TAP_MATCHES_CODE: assert property (@(posedge clk) disable iff (rst)
      tap_sel[wiper_code] == 1'b1); // R8

   AST_ZERO_FLAG_AGREES: assert property (@(posedge clk) disable iff (rst)
      zero_tap == tap_sel[0]); // R9

   AST_HOLD_WITHOUT_LOAD: assert property (@(posedge clk) disable iff (rst)
      !load_pulse |-> $stable(wiper_code)); // R3

   AST_LOAD_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      load_pulse |=> !load_pulse); // R7

endmodule

bind serial_wiper_loader wiper_loader_chk #(.CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .wiper_code (wiper_code),
   .tap_sel    (tap_sel),
   .zero_tap   (zero_tap),
   .load_pulse (load_pulse)
);

// File: tb/serial_wiper_loader_tb.sv
module serial_wiper_loader_tb;

   localparam int CW   = 8;
   localparam int TAPS = 1 << CW;

   logic            clk = 1'b0;
   logic            rst = 1'b1;
   logic            sclk = 1'b0;
   logic            sdata = 1'b0;
   logic            sel = 1'b0;
   logic [CW-1:0]   wiper_code;
   logic [TAPS-1:0] tap_sel;
   logic            zero_tap;
   logic            load_pulse;

   int checks = 0;
   int errors = 0;
   logic [CW-1:0] model_shift = '0;
   logic [CW-1:0] model_wiper = 8'h80;

   always #4 clk = ~clk;

   serial_wiper_loader u_dut (
      .clk        (clk),
      .rst        (rst),
      .sclk       (sclk),
      .sdata      (sdata),
      .sel        (sel),
      .wiper_code (wiper_code),
      .tap_sel    (tap_sel),
      .zero_tap   (zero_tap),
      .load_pulse (load_pulse)
   );

   function automatic int first_set(input logic [TAPS-1:0] v);
      for (int i = 0; i < TAPS; i++) if (v[i]) return i;
      return -1;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic check_outputs(input string req);
      logic [TAPS-1:0] exp_tap;
      exp_tap = {{(TAPS-1){1'b0}}, 1'b1} << model_wiper;
      check(wiper_code == model_wiper, req, "wiper_code", wiper_code, model_wiper);
      check(tap_sel == exp_tap, req, "tap_sel index", first_set(tap_sel), model_wiper);
      check(zero_tap == (model_wiper == 0), req, "zero_tap", zero_tap, model_wiper == 0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1; sel = 1'b0; sclk = 1'b0; sdata = 1'b0;
      repeat (3) @(negedge clk);
      check(load_pulse == 1'b0, "R1", "load_pulse in reset", load_pulse, 0);
      rst = 1'b0;
      model_shift = '0;
      model_wiper = 8'h80;
      @(negedge clk);
      check(load_pulse == 1'b0, "R1", "load_pulse after reset", load_pulse, 0);
      check_outputs("R1");
   endtask

   // Select window with nbits bits taken MSB first from bits[nbits-1:0]
   task automatic run_window(input int nbits, input logic [31:0] bits, input string req);
      sel = 1'b1;
      repeat (4) @(negedge clk);
      for (int i = nbits - 1; i >= 0; i--) begin
         sdata = bits[i];
         model_shift = {model_shift[CW-2:0], bits[i]};
         sclk = 1'b0;
         repeat (4) @(negedge clk);
         sclk = 1'b1;
         repeat (4) @(negedge clk);
      end
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      check(wiper_code == model_wiper, req, "wiper before commit", wiper_code, model_wiper);
      sel = 1'b0;
      model_wiper = model_shift;
      @(negedge clk);
      @(negedge clk);
      check(load_pulse == 1'b0, "R7", "load_pulse early", load_pulse, 0);
      @(negedge clk);
      check(load_pulse == 1'b1, "R7", "load_pulse due", load_pulse, 1);
      check_outputs(req);
      @(negedge clk);
      check(load_pulse == 1'b0, "R7", "load_pulse width", load_pulse, 0);
   endtask

   task automatic test_basic();
      run_window(8, 32'hA5, "R2");
      run_window(8, 32'h3C, "R2");
   endtask

   task automatic test_extremes();
      run_window(8, 32'h00, "R9");
      run_window(8, 32'hFF, "R8");
      run_window(8, 32'h01, "R8");
   endtask

   task automatic test_overflow();
      run_window(12, 32'hABC, "R4");
      run_window(11, 32'h7E5, "R4");
   endtask

   task automatic test_clock_while_idle();
      logic [CW-1:0] held;
      int pulses;
      held = wiper_code;
      pulses = 0;
      for (int k = 0; k < 6; k++) begin
         sdata = k[0];
         sclk = 1'b1;
         repeat (4) begin @(negedge clk); if (load_pulse) pulses++; end
         sclk = 1'b0;
         repeat (4) begin @(negedge clk); if (load_pulse) pulses++; end
      end
      check(pulses == 0, "R3", "load pulses with sel low", pulses, 0);
      check(wiper_code == held, "R3", "wiper with sel low", wiper_code, held);
      // shift register must be untouched: a 4-bit window exposes its old bits
      run_window(4, 32'h3, "R3");
   endtask

   task automatic test_partial();
      run_window(8, 32'hC9, "R5");
      run_window(3, 32'h2, "R5");
   endtask

   task automatic test_after_reset();
      do_reset();
      run_window(3, 32'h5, "R6");
      check(wiper_code == 8'h05, "R6", "short window after reset", wiper_code, 8'h05);
   endtask

   task automatic test_empty_window();
      run_window(8, 32'h6E, "R10");
      run_window(0, 32'h0, "R10");
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      test_basic();
      test_extremes();
      test_overflow();
      test_clock_while_idle();
      test_partial();
      test_after_reset();
      test_empty_window();
      repeat (4) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule